// File: doc/BRIEF.md
# Effective Address Generator for 32-bit Memory Operands

This block turns the addressing bytes that follow an opcode into a memory operand address. It takes one byte per cycle under a valid/ready handshake. The first byte is the register/memory descriptor (ModRM). When that byte asks for a scale-index-base (SIB) byte, the SIB byte comes next. After that come zero, one or four displacement bytes. Once the last required byte has been taken, the block adds the base register, the scaled index and the displacement to form the offset. It then adds the chosen segment base to form the linear address.

The eight general registers arrive on one flat parallel bus. Register number i occupies bits [32*i+31 : 32*i], and the numbering is 0=EAX, 1=ECX, 2=EDX, 3=EBX, 4=ESP, 5=EBP, 6=ESI, 7=EDI. Two default segment bases (data and stack) and an override base with its enable flag come in beside the register bus. All of these inputs are sampled in the cycle that the final byte is accepted. A descriptor with mod=3 names a register, not memory; the block flags it and finishes at once.

Top module: `ea32_gen`

## Requirements
- R1: With mod=0 and rm not 4 or 5, the offset equals the register selected by rm, the data segment is the default, and no further byte is taken after the descriptor. The descriptor fields are mod=bits[7:6] and rm=bits[2:0].
- R2: With mod=1, exactly one displacement byte follows. It is sign-extended to 32 bits and added to the base.
- R3: With mod=2, four displacement bytes follow, least significant byte first, and their 32-bit value is added to the base.
- R4: With mod=0 and rm=5, four displacement bytes follow and the offset is that value alone, with the data segment as the default.
- R5: With rm=5 and mod=1 or mod=2, EBP is the base and the stack segment is the default.
- R6: With rm=4, the next byte is the SIB byte (scale=bits[7:6], index=bits[5:3], base=bits[2:0]), and it is consumed before any displacement byte. Its base field selects the base register. A base of 4 (ESP) defaults to the stack segment, and the other bases default to the data segment.
- R7: A SIB base of 5 with mod=0 means no base register: four displacement bytes follow and the data segment is the default. A SIB base of 5 with mod=1 or mod=2 means EBP with the stack segment.
- R8: The SIB index selects a register in the same numbering, shifted left by the scale (a factor of 1, 2, 4 or 8). An index of 4 adds zero.
- R9: When the override enable is high, the override base replaces the default segment base in the linear address, and the offset does not change.
- R10: Every sum wraps modulo 2^32.
- R11: done is high for exactly the one cycle after the last required byte is accepted. A descriptor is accepted in that same cycle, and done is never high without a finished operand. A synchronous reset discards any partly collected operand and leaves done, the flag, the offset and the linear address at zero.
- R12: A descriptor with mod=3 finishes alone. It raises done with the not-memory flag set and with offset and linear address both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Descriptor, SIB or displacement byte |
| in_ready | output | 1 | The block can take a byte (always high) |
| gpr_flat | input | 256 | Eight 32-bit registers, register i at bits [32*i+31:32*i] |
| ds_base | input | 32 | Default data segment base |
| ss_base | input | 32 | Default stack segment base |
| ovr_en | input | 1 | Use ovr_base in place of the default segment |
| ovr_base | input | 32 | Override segment base |
| done | output | 1 | One-cycle completion pulse |
| nomem | output | 1 | The completed descriptor named a register (mod=3) |
| ea_off | output | 32 | Computed offset |
| ea_lin | output | 32 | Segment base plus offset |

## Verification
The assertions take for granted that the register bus, both default segment bases and the override controls keep their value through the cycle that accepts the final byte, because the results are compared against the previous cycle's inputs. The assertions also assume that the source never drops a byte once a descriptor has started. The bench changes registers and bases only after an idle cycle that follows a completed operand. It feeds each operand's bytes on consecutive cycles, so the byte count of an operand is never stretched by gaps.

// File: rtl/ea32_pkg.sv
`timescale 1ns/1ps
package ea32_pkg;

   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned DISP_MAX_B  = 4;

   typedef enum logic [1:0] {
      PH_MODRM = 2'd0,
      PH_SIB   = 2'd1,
      PH_DISP  = 2'd2
   } ea_phase_e;

   localparam logic [1:0] MOD_NOOFS  = 2'b00;
   localparam logic [1:0] MOD_D8     = 2'b01;
   localparam logic [1:0] MOD_D32    = 2'b10;
   localparam logic [1:0] MOD_REG    = 2'b11;
   localparam logic [2:0] RM_HAS_SIB = 3'd4;
   localparam logic [2:0] BASE_SPEC  = 3'd5;   // no base (mod 0) or EBP
   localparam logic [2:0] IDX_ZERO   = 3'd4;
   localparam logic [2:0] BASE_STACK = 3'd4;

   // Number of displacement bytes implied by mod and the base selector
   function automatic logic [2:0] disp_count(input logic [1:0] md, input logic [2:0] bsel);
      case (md)
         MOD_D8:    return 3'd1;
         MOD_D32:   return 3'd4;
         MOD_NOOFS: return (bsel == BASE_SPEC) ? 3'd4 : 3'd0;
         default:   return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/ea32_parse.sv
`timescale 1ns/1ps
module ea32_parse
   import ea32_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   output logic          fin,
   output logic          f_nomem,
   output logic [1:0]    f_mod,
   output logic [2:0]    f_rm,
   output logic [7:0]    f_sib,
   output logic [AW-1:0] f_disp
);

   localparam int IDX_W = $clog2(DISP_MAX_B);

   ea_phase_e         ph_q, ph_d;
   logic [1:0]        mod_q, mod_d;
   logic [2:0]        rm_q, rm_d;
   logic [7:0]        sib_q, sib_d;
   logic [AW-1:0]     disp_q, disp_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [2:0]        len_q, len_d;
   logic [2:0]        want;
   logic [AW-1:0]     byte_pos;

   assign byte_pos = {{(AW-BYTE_W){1'b0}}, in_byte} << {idx_q, 3'b000};

   always_comb begin
      ph_d    = ph_q;
      mod_d   = mod_q;
      rm_d    = rm_q;
      sib_d   = sib_q;
      disp_d  = disp_q;
      idx_d   = idx_q;
      len_d   = len_q;
      fin     = 1'b0;
      f_nomem = 1'b0;
      want    = 3'd0;
      if (in_valid) begin
         unique case (ph_q)
            PH_MODRM: begin
               mod_d  = in_byte[7:6];
               rm_d   = in_byte[2:0];
               sib_d  = '0;
               disp_d = '0;
               idx_d  = '0;
               if (in_byte[7:6] == MOD_REG) begin
                  fin     = 1'b1;
                  f_nomem = 1'b1;
               end else if (in_byte[2:0] == RM_HAS_SIB) begin
                  ph_d = PH_SIB;
               end else begin
                  want  = disp_count(in_byte[7:6], in_byte[2:0]);
                  len_d = want;
                  if (want == 3'd0) fin = 1'b1;
                  else              ph_d = PH_DISP;
               end
            end
            PH_SIB: begin
               sib_d = in_byte;
               want  = disp_count(mod_q, in_byte[2:0]);
               len_d = want;
               if (want == 3'd0) begin
                  fin  = 1'b1;
                  ph_d = PH_MODRM;
               end else begin
                  ph_d = PH_DISP;
               end
            end
            PH_DISP: begin
               idx_d = idx_q + 1'b1;
               if (len_q == 3'd1)
                  disp_d = {{(AW-BYTE_W){in_byte[7]}}, in_byte};
               else
                  disp_d = disp_q | byte_pos;
               if ({1'b0, idx_q} == len_q - 3'd1) begin
                  fin  = 1'b1;
                  ph_d = PH_MODRM;
               end
            end
            default: ph_d = PH_MODRM;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q   <= PH_MODRM;
         mod_q  <= '0;
         rm_q   <= '0;
         sib_q  <= '0;
         disp_q <= '0;
         idx_q  <= '0;
         len_q  <= '0;
      end else begin
         ph_q   <= ph_d;
         mod_q  <= mod_d;
         rm_q   <= rm_d;
         sib_q  <= sib_d;
         disp_q <= disp_d;
         idx_q  <= idx_d;
         len_q  <= len_d;
      end
   end

   assign f_mod  = mod_d;
   assign f_rm   = rm_d;
   assign f_sib  = sib_d;
   assign f_disp = disp_d;

endmodule

// File: rtl/ea32_sum.sv
`timescale 1ns/1ps
module ea32_sum
   import ea32_pkg::*;
#(
   parameter int AW   = 32,
   parameter int NREG = 8
) (
   input  logic [1:0]         md,
   input  logic [2:0]         rm,
   input  logic [7:0]         sib,
   input  logic [AW-1:0]      disp,
   input  logic [NREG*AW-1:0] gpr_flat,
   input  logic [AW-1:0]      ds_base,
   input  logic [AW-1:0]      ss_base,
   input  logic               ovr_en,
   input  logic [AW-1:0]      ovr_base,
   output logic [AW-1:0]      off,
   output logic [AW-1:0]      lin
);

   logic [AW-1:0] gpr [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign gpr[g] = gpr_flat[g*AW +: AW];
   end

   logic [2:0]    bsel;
   logic          no_base;
   logic          stack_def;
   logic [AW-1:0] base_v;
   logic [AW-1:0] index_v;
   logic [AW-1:0] seg_v;

   always_comb begin
      if (rm == RM_HAS_SIB) begin
         bsel      = sib[2:0];
         no_base   = (md == MOD_NOOFS) && (sib[2:0] == BASE_SPEC);
         stack_def = (sib[2:0] == BASE_STACK) ||
                     ((sib[2:0] == BASE_SPEC) && (md != MOD_NOOFS));
         index_v   = (sib[5:3] == IDX_ZERO) ? '0 : (gpr[sib[5:3]] << sib[7:6]);
      end else begin
         bsel      = rm;
         no_base   = (md == MOD_NOOFS) && (rm == BASE_SPEC);
         stack_def = (rm == BASE_SPEC) && (md != MOD_NOOFS);
         index_v   = '0;
      end
      base_v = no_base ? '0 : gpr[bsel];
      off    = base_v + index_v + disp;
      if (ovr_en)         seg_v = ovr_base;
      else if (stack_def) seg_v = ss_base;
      else                seg_v = ds_base;
      lin = seg_v + off;
   end

endmodule

// File: rtl/ea32_gen.sv
`timescale 1ns/1ps
module ea32_gen
   import ea32_pkg::*;
#(
   parameter int AW   = 32,
   parameter int NREG = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [7:0]         in_byte,
   output logic               in_ready,
   input  logic [NREG*AW-1:0] gpr_flat,
   input  logic [AW-1:0]      ds_base,
   input  logic [AW-1:0]      ss_base,
   input  logic               ovr_en,
   input  logic [AW-1:0]      ovr_base,
   output logic               done,
   output logic               nomem,
   output logic [AW-1:0]      ea_off,
   output logic [AW-1:0]      ea_lin
);

   if (AW != 32) begin : g_bad_aw
      $error("ea32_gen: AW must be 32 for 32-bit addressing");
   end
   if (NREG != 8) begin : g_bad_nreg
      $error("ea32_gen: NREG must be 8");
   end

   logic          fin, f_nomem;
   logic [1:0]    f_mod;
   logic [2:0]    f_rm;
   logic [7:0]    f_sib;
   logic [AW-1:0] f_disp, s_off, s_lin;

   assign in_ready = 1'b1;

   ea32_parse #(.AW(AW)) u_parse (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .fin      (fin),
      .f_nomem  (f_nomem),
      .f_mod    (f_mod),
      .f_rm     (f_rm),
      .f_sib    (f_sib),
      .f_disp   (f_disp)
   );

   ea32_sum #(.AW(AW), .NREG(NREG)) u_sum (
      .md       (f_mod),
      .rm       (f_rm),
      .sib      (f_sib),
      .disp     (f_disp),
      .gpr_flat (gpr_flat),
      .ds_base  (ds_base),
      .ss_base  (ss_base),
      .ovr_en   (ovr_en),
      .ovr_base (ovr_base),
      .off      (s_off),
      .lin      (s_lin)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done   <= 1'b0;
         nomem  <= 1'b0;
         ea_off <= '0;
         ea_lin <= '0;
      end else begin
         done <= fin;
         if (fin) begin
            nomem  <= f_nomem;
            ea_off <= f_nomem ? '0 : s_off;
            ea_lin <= f_nomem ? '0 : s_lin;
         end
      end
   end

endmodule

// File: rtl/ea32_chk.sv
`timescale 1ns/1ps
module ea32_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [AW-1:0] ds_base,
   input logic [AW-1:0] ss_base,
   input logic          ovr_en,
   input logic [AW-1:0] ovr_base,
   input logic          done,
   input logic          nomem,
   input logic [AW-1:0] ea_off,
   input logic [AW-1:0] ea_lin
);

   AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(in_valid));                                             // R11

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !done);                                                 // R11

   AST_REG_FORM_ZERO: assert property (@(posedge clk) disable iff (rst)
      (done && nomem) |-> (ea_off == '0 && ea_lin == '0));                   // R12

   AST_OVR_SEGMENT: assert property (@(posedge clk) disable iff (rst)
      (done && !nomem && $past(ovr_en)) |-> (ea_lin == $past(ovr_base) + ea_off)); // R9

   AST_DEFAULT_SEGMENT: assert property (@(posedge clk) disable iff (rst)
      (done && !nomem && !$past(ovr_en)) |->
      ((ea_lin == $past(ds_base) + ea_off) || (ea_lin == $past(ss_base) + ea_off))); // R6

endmodule

bind ea32_gen ea32_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .ds_base  (ds_base),
   .ss_base  (ss_base),
   .ovr_en   (ovr_en),
   .ovr_base (ovr_base),
   .done     (done),
   .nomem    (nomem),
   .ea_off   (ea_off),
   .ea_lin   (ea_lin)
);

// File: tb/tb_ea32_gen.sv
`timescale 1ns/1ps
module tb_ea32_gen;

   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   logic          in_valid = 1'b0;
   logic [7:0]    in_byte  = '0;
   logic          in_ready;
   logic [AW-1:0] rv [8];
   logic [8*AW-1:0] gpr_flat;
   logic [AW-1:0] ds_base = '0, ss_base = '0, ovr_base = '0;
   logic          ovr_en = 1'b0;
   logic          done, nomem;
   logic [AW-1:0] ea_off, ea_lin;

   always_comb for (int i = 0; i < 8; i++) gpr_flat[i*AW +: AW] = rv[i];

   ea32_gen dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
      .gpr_flat(gpr_flat), .ds_base(ds_base), .ss_base(ss_base), .ovr_en(ovr_en),
      .ovr_base(ovr_base), .done(done), .nomem(nomem), .ea_off(ea_off), .ea_lin(ea_lin)
   );

   int cycles = 0;
   always @(posedge clk) cycles <= cycles + 1;

   int errs = 0, checks = 0;
   bit ended = 1'b0;

   typedef struct {
      logic [31:0] off;
      logic [31:0] lin;
      logic        nm;
      int          cyc;
      string       tag;
   } exp_t;
   exp_t sb[$];

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // Monitor: pop one expectation per done pulse
   always @(negedge clk) begin
      if (!rst && !ended && done) begin
         if (sb.size() == 0) begin
            checks++; errs++;
            $display("FAIL R11 done without operand: actual=1 expected=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "nomem", {31'b0, nomem}, {31'b0, e.nm});
            chk(e.tag, "offset", ea_off, e.off);
            chk(e.tag, "linear", ea_lin, e.lin);
            chk("R11", "done cycle", cycles, e.cyc);
         end
      end
   end

   function automatic int dlen(input logic [1:0] md, input logic [2:0] bf);
      if (md == 2'd1) return 1;
      if (md == 2'd2) return 4;
      if (md == 2'd0 && bf == 3'd5) return 4;
      return 0;
   endfunction

   function automatic exp_t model(input logic [7:0] m, input logic [7:0] s,
                                  input logic [31:0] d, input string tag);
      exp_t e;
      logic [1:0] md = m[7:6];
      logic [2:0] r  = m[2:0];
      logic [2:0] bf;
      logic [31:0] bv, iv, dv, seg;
      bit onss;
      int n;
      e.tag = tag; e.cyc = 0;
      if (md == 2'd3) begin
         e.nm = 1'b1; e.off = 0; e.lin = 0;
         return e;
      end
      e.nm = 1'b0;
      bf = (r == 3'd4) ? s[2:0] : r;
      n  = dlen(md, bf);
      dv = (n == 1) ? {{24{d[7]}}, d[7:0]} : (n == 4) ? d : 32'h0;
      bv = (md == 2'd0 && bf == 3'd5) ? 32'h0 : rv[bf];
      if (r == 3'd4) begin
         iv   = (s[5:3] == 3'd4) ? 32'h0 : (rv[s[5:3]] << s[7:6]);
         onss = (bf == 3'd4) || (bf == 3'd5 && md != 2'd0);
      end else begin
         iv   = 32'h0;
         onss = (r == 3'd5 && md != 2'd0);
      end
      e.off = bv + iv + dv;
      seg   = ovr_en ? ovr_base : (onss ? ss_base : ds_base);
      e.lin = seg + e.off;
      return e;
   endfunction

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Driver: send one operand's bytes and push its expected result
   task automatic op(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d, input string tag);
      logic [7:0] bytes [6];
      int k = 0, n = 0;
      exp_t e;
      bytes[k] = m; k = k + 1;
      if (m[7:6] != 2'd3) begin
         if (m[2:0] == 3'd4) begin bytes[k] = s; k = k + 1; end
         n = dlen(m[7:6], (m[2:0] == 3'd4) ? s[2:0] : m[2:0]);
         for (int i = 0; i < n; i++) begin bytes[k] = d[8*i +: 8]; k = k + 1; end
      end
      for (int i = 0; i < k; i++) put(bytes[i]);
      e = model(m, s, d, tag);
      e.cyc = cycles + 1;
      sb.push_back(e);
   endtask

   task automatic load_regs(input logic [31:0] seed);
      for (int i = 0; i < 8; i++) rv[i] = seed + 32'h0101_0000 * i + i;
      ds_base = 32'h0001_0000; ss_base = 32'h0020_0000;
      ovr_en = 1'b0; ovr_base = 32'h0300_0000;
   endtask

   initial begin
      #(20 * 100000);
      if (!ended) begin
         ended = 1'b1; checks++; errs++;
         $display("FAIL R11 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      load_regs(32'h1000);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // reset state, R11
      chk("R11", "reset done", {31'b0, done}, 32'h0);
      chk("R11", "reset nomem", {31'b0, nomem}, 32'h0);
      chk("R11", "reset offset", ea_off, 32'h0);
      chk("R11", "reset linear", ea_lin, 32'h0);
      chk("R11", "ready", {31'b0, in_ready}, 32'h1);

      op(8'h03, 8'h00, 32'h0, "R1");            // [EBX]
      idle();
      op(8'h06, 8'h00, 32'h0, "R1");            // [ESI]
      idle();
      op(8'h41, 8'h00, 32'h0000_00FD, "R2");    // [ECX-3]
      idle();
      op(8'h40, 8'h00, 32'h0000_007F, "R2");    // [EAX+127]
      idle();
      op(8'h86, 8'h00, 32'h1234_5678, "R3");    // [ESI+disp32]
      idle();
      op(8'h05, 8'h00, 32'hCAFE_0042, "R4");    // disp32 only
      idle();
      op(8'h45, 8'h00, 32'h0000_0080, "R5");    // [EBP-128], SS
      idle();
      op(8'h85, 8'h00, 32'h0000_1000, "R5");
      idle();
      op(8'h04, 8'h4C, 32'h0, "R6");            // SIB base ESP, idx ECX*2
      idle();
      op(8'h04, 8'h1A, 32'h0, "R6");            // SIB base EDX, idx EBX*1
      idle();
      op(8'h04, 8'hF5, 32'h0000_2000, "R7");    // no base, idx ESI*8, disp32
      idle();
      op(8'h44, 8'h2D, 32'h0000_0010, "R7");    // EBP base via SIB, SS
      idle();
      op(8'h84, 8'hE7, 32'h8000_0000, "R8");    // idx 4 contributes zero, scale 3
      idle();
      op(8'h84, 8'hB8, 32'h0000_0004, "R8");    // idx EDI*4
      idle();
      ovr_en = 1'b1;
      op(8'h45, 8'h00, 32'h0000_0008, "R9");    // override replaces SS
      idle();
      op(8'h04, 8'h00, 32'h0, "R9");
      idle();
      ovr_en = 1'b0;
      rv[0] = 32'hFFFF_FFF0; ds_base = 32'hF000_0000;
      op(8'h80, 8'h00, 32'h0000_0020, "R10");   // wraps
      idle();
      rv[7] = 32'h8000_0001;
      op(8'h04, 8'hF8, 32'h0, "R10");           // EAX + EDI*8 wraps
      idle();
      // mod=3 and back-to-back descriptors
      op(8'hC3, 8'h00, 32'h0, "R12");
      op(8'h01, 8'h00, 32'h0, "R11");
      op(8'hD8, 8'h00, 32'h0, "R12");
      op(8'h42, 8'h00, 32'h0000_0001, "R11");
      idle();
      // reset in the middle of a displacement
      put(8'h80); put(8'hAA);
      @(negedge clk); in_valid = 1'b0; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11", "done after mid reset", {31'b0, done}, 32'h0);
      op(8'h02, 8'h00, 32'h0, "R11");
      idle();
      for (int i = 0; i < 40; i++) begin
         idle();
         for (int j = 0; j < 8; j++) rv[j] = $urandom;
         ds_base = $urandom; ss_base = $urandom; ovr_base = $urandom;
         ovr_en = 1'($urandom);
         op(8'($urandom), 8'($urandom), $urandom, "R10");
      end
      repeat (3) idle();
      chk("R11", "pending operands", sb.size(), 32'h0);
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule